// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two bidirectional data buses, called A and B here, through a pair of storage registers. Each transfer direction owns a register with a capture strobe, a select that picks live or stored data for the bus it drives, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The word is cut into equal slices, two by default. Each slice has a full private set of strobes, selects and enables, so the block can serve as several narrow transceivers or as one wide one.

The block runs on one system clock. Each capture strobe is sampled, and a register loads on the cycle in which its strobe is first seen high. Tri-state buses are modelled with separate signals for each side: the value driven in from outside, whether anything outside is driving, the value the block drives, and the block's own output enable. Each bus side has a keeper register that holds the last value the bus resolved to. An undriven bus therefore reads as that held value. If both directions are enabled in live mode, the two buses reinforce each other and keep their value with no external driver.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers and both keepers to 0. After reset, stored data reads 0 on any enabled output, and an undriven bus reads 0.
- R2: For each slice, `a_oe` equals the inverse of `oe_ba_n` and `b_oe` equals `oe_ab`. A disabled output presents all zeros on its data lines.
- R3: With `oe_ab`=1 and `sel_ab`=0, and bus A driven only from outside, `b_out` equals `a_in` in the same cycle.
- R4: With `oe_ba_n`=0 and `sel_ba`=0, and bus B driven only from outside, `a_out` equals `b_in` in the same cycle.
- R5: The A-to-B register loads the resolved bus A value on the first clock edge at which `cap_ab` is sampled 1 after being sampled 0. While `cap_ab` stays high it loads nothing further. With `sel_ab`=1 and `oe_ab`=1, `b_out` shows the register from the next cycle on.
- R6: Capture does not depend on the select or enable inputs, and it also takes place while both outputs are disabled.
- R7: The B-to-A register loads the resolved bus B value on a sampled rising edge of `cap_ba`. With `sel_ba`=1 and `oe_ba_n`=0, `a_out` shows it.
- R8: When the block itself drives a bus, a capture from that bus stores the value the block is driving onto it.
- R9: A bus that neither the block nor an outside source drives reads as the last value it resolved to, and a live transfer forwards that held value.
- R10: With both outputs enabled and both selects 0 in a slice, both buses carry the A-side held value. They keep it while no outside source drives either bus.
- R11: Slices are independent. Strobes, selects and enables of one slice affect only that slice's bits: slice 0 is bits 7:0 and slice 1 is bits 15:8 by default.
- R12: Toggling a select when the live and stored values are equal leaves the driven output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | DATA_W | Value driven onto bus A from outside |
| a_ext_drv | input | NUM_SLICES | Per slice: an outside source drives bus A |
| b_in | input | DATA_W | Value driven onto bus B from outside |
| b_ext_drv | input | NUM_SLICES | Per slice: an outside source drives bus B |
| cap_ab | input | NUM_SLICES | Capture strobe of the A-to-B register |
| cap_ba | input | NUM_SLICES | Capture strobe of the B-to-A register |
| sel_ab | input | NUM_SLICES | Source for bus B: 0 live, 1 stored |
| sel_ba | input | NUM_SLICES | Source for bus A: 0 live, 1 stored |
| oe_ab | input | NUM_SLICES | Drive enable for bus B, active high |
| oe_ba_n | input | NUM_SLICES | Drive enable for bus A, active low |
| a_out | output | DATA_W | Value the block drives onto bus A |
| a_oe | output | NUM_SLICES | Block drives bus A |
| b_out | output | DATA_W | Value the block drives onto bus B |
| b_oe | output | NUM_SLICES | Block drives bus B |

## Verification
The hardest state to reach from the ports is the mutual-reinforcement loop. It only shows something when the keeper already holds a non-zero value and every outside driver has then been withdrawn. The stimulus first runs a live A-to-B transfer so that the A-side keeper loads a known pattern. It then releases bus A and enables the opposite direction in live mode on the same edge, and holds that state for several cycles to show that the value persists. Capturing from a bus the block is itself driving is reached in a similar way: a live B-to-A transfer runs while the A-to-B strobe is pulsed, and the captured value is read back later through a stored-data transfer onto B.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which buses the slice itself drives, and whether both are live.
   typedef enum logic [2:0] {
      PATH_NONE = 3'd0,
      PATH_TO_A = 3'd1,
      PATH_TO_B = 3'd2,
      PATH_BOTH = 3'd3,
      PATH_LOOP = 3'd4
   } path_e;

   function automatic path_e path_of(input logic a_drv, input logic b_drv,
                                     input logic s_ab, input logic s_ba);
      path_e p;
      unique case ({a_drv, b_drv})
         2'b00:   p = PATH_NONE;
         2'b10:   p = PATH_TO_A;
         2'b01:   p = PATH_TO_B;
         default: p = (!s_ab && !s_ba) ? PATH_LOOP : PATH_BOTH;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] last_q;

   always_ff @(posedge clk) begin
      if (rst) last_q <= '0;
      else     last_q <= lvl;
   end

   assign rise = lvl & ~last_q;
endmodule

// File: rtl/xcvr_slice.sv
module xcvr_slice
   import xcvr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic         a_ext,
   input  logic [W-1:0] b_in,
   input  logic         b_ext,
   input  logic         hit_ab,
   input  logic         hit_ba,
   input  logic         s_ab,
   input  logic         s_ba,
   input  logic         a_drv,
   input  logic         b_drv,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out
);
   logic [W-1:0] store_ab_q, store_ba_q;
   logic [W-1:0] hold_a_q, hold_b_q;
   logic [W-1:0] a_outside, b_outside;
   logic [W-1:0] a_bus, b_bus;
   path_e        path;

   assign a_outside = a_ext ? a_in : hold_a_q;
   assign b_outside = b_ext ? b_in : hold_b_q;
   assign path      = path_of(a_drv, b_drv, s_ab, s_ba);

   // Resolved bus values, written without a structural loop between sides.
   always_comb begin
      a_bus = a_outside;
      b_bus = b_outside;
      unique case (path)
         PATH_NONE: begin
            a_bus = a_outside;
            b_bus = b_outside;
         end
         PATH_TO_B: begin
            a_bus = a_outside;
            b_bus = s_ab ? store_ab_q : a_outside;
         end
         PATH_TO_A: begin
            b_bus = b_outside;
            a_bus = s_ba ? store_ba_q : b_outside;
         end
         PATH_BOTH: begin
            a_bus = s_ba ? store_ba_q : store_ab_q;
            b_bus = s_ab ? store_ab_q : store_ba_q;
         end
         PATH_LOOP: begin
            a_bus = hold_a_q;
            b_bus = hold_a_q;
         end
         default: begin
            a_bus = a_outside;
            b_bus = b_outside;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         store_ab_q <= '0;
         store_ba_q <= '0;
         hold_a_q   <= '0;
         hold_b_q   <= '0;
      end else begin
         hold_a_q <= a_bus;
         hold_b_q <= b_bus;
         if (hit_ab) store_ab_q <= a_bus;
         if (hit_ba) store_ba_q <= b_bus;
      end
   end

   assign a_out = a_drv ? a_bus : '0;
   assign b_out = b_drv ? b_bus : '0;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
   parameter int DATA_W     = 16,
   parameter int NUM_SLICES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [DATA_W-1:0]     a_in,
   input  logic [NUM_SLICES-1:0] a_ext_drv,
   input  logic [DATA_W-1:0]     b_in,
   input  logic [NUM_SLICES-1:0] b_ext_drv,
   input  logic [NUM_SLICES-1:0] cap_ab,
   input  logic [NUM_SLICES-1:0] cap_ba,
   input  logic [NUM_SLICES-1:0] sel_ab,
   input  logic [NUM_SLICES-1:0] sel_ba,
   input  logic [NUM_SLICES-1:0] oe_ab,
   input  logic [NUM_SLICES-1:0] oe_ba_n,
   output logic [DATA_W-1:0]     a_out,
   output logic [NUM_SLICES-1:0] a_oe,
   output logic [DATA_W-1:0]     b_out,
   output logic [NUM_SLICES-1:0] b_oe
);
   localparam int SLICE_W = DATA_W / NUM_SLICES;

   initial begin
      if (NUM_SLICES < 1 || DATA_W % NUM_SLICES != 0)
         $error("bus_xcvr_reg: DATA_W must split evenly into NUM_SLICES");
   end

   logic [NUM_SLICES-1:0] hit_ab, hit_ba;

   assign a_oe = ~oe_ba_n;
   assign b_oe = oe_ab;

   xcvr_edge #(.N(NUM_SLICES)) u_edge_ab (.clk(clk), .rst(rst), .lvl(cap_ab), .rise(hit_ab));
   xcvr_edge #(.N(NUM_SLICES)) u_edge_ba (.clk(clk), .rst(rst), .lvl(cap_ba), .rise(hit_ba));

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      xcvr_slice #(.W(SLICE_W)) u_slice (
         .clk    (clk),
         .rst    (rst),
         .a_in   (a_in[s*SLICE_W +: SLICE_W]),
         .a_ext  (a_ext_drv[s]),
         .b_in   (b_in[s*SLICE_W +: SLICE_W]),
         .b_ext  (b_ext_drv[s]),
         .hit_ab (hit_ab[s]),
         .hit_ba (hit_ba[s]),
         .s_ab   (sel_ab[s]),
         .s_ba   (sel_ba[s]),
         .a_drv  (a_oe[s]),
         .b_drv  (b_oe[s]),
         .a_out  (a_out[s*SLICE_W +: SLICE_W]),
         .b_out  (b_out[s*SLICE_W +: SLICE_W])
      );
   end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
   parameter int DATA_W     = 16,
   parameter int NUM_SLICES = 2
) (
   input logic                  clk,
   input logic                  rst,
   input logic [DATA_W-1:0]     a_in,
   input logic [NUM_SLICES-1:0] a_ext_drv,
   input logic [DATA_W-1:0]     b_in,
   input logic [NUM_SLICES-1:0] b_ext_drv,
   input logic [NUM_SLICES-1:0] cap_ab,
   input logic [NUM_SLICES-1:0] sel_ab,
   input logic [NUM_SLICES-1:0] sel_ba,
   input logic [DATA_W-1:0]     a_out,
   input logic [NUM_SLICES-1:0] a_oe,
   input logic [DATA_W-1:0]     b_out,
   input logic [NUM_SLICES-1:0] b_oe
);
   localparam int SW = DATA_W / NUM_SLICES;

   logic [NUM_SLICES-1:0] strobe_seen_q;
   always_ff @(posedge clk) begin
      if (rst) strobe_seen_q <= '0;
      else     strobe_seen_q <= cap_ab;
   end

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_chk
      assert_a_quiet_R2: assert property (@(posedge clk) disable iff (rst)
         !a_oe[s] |-> a_out[s*SW +: SW] == '0);
      assert_b_quiet_R2: assert property (@(posedge clk) disable iff (rst)
         !b_oe[s] |-> b_out[s*SW +: SW] == '0);
      assert_live_ab_R3: assert property (@(posedge clk) disable iff (rst)
         (b_oe[s] && !sel_ab[s] && !a_oe[s] && a_ext_drv[s])
            |-> b_out[s*SW +: SW] == a_in[s*SW +: SW]);
      assert_live_ba_R4: assert property (@(posedge clk) disable iff (rst)
         (a_oe[s] && !sel_ba[s] && !b_oe[s] && b_ext_drv[s])
            |-> a_out[s*SW +: SW] == b_in[s*SW +: SW]);
      assert_loop_match_R10: assert property (@(posedge clk) disable iff (rst)
         (a_oe[s] && b_oe[s] && !sel_ab[s] && !sel_ba[s])
            |-> a_out[s*SW +: SW] == b_out[s*SW +: SW]);
      assert_store_hold_R5: assert property (@(posedge clk) disable iff (rst)
         (b_oe[s] && sel_ab[s] && $past(!rst) && $past(b_oe[s] && sel_ab[s])
            && !$past(cap_ab[s] && !strobe_seen_q[s]))
            |-> $stable(b_out[s*SW +: SW]));
   end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.DATA_W(DATA_W), .NUM_SLICES(NUM_SLICES)) u_chk (.*);

// File: tb/bus_xcvr_reg_tb_top.sv
module bus_xcvr_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int NS = 2;

   typedef struct {
      string         req;
      logic [DW-1:0] ea;
      logic [DW-1:0] eb;
      logic [NS-1:0] eoa;
      logic [NS-1:0] eob;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] a_in = '0, b_in = '0;
   logic [NS-1:0] a_ext_drv = '0, b_ext_drv = '0;
   logic [NS-1:0] cap_ab = '0, cap_ba = '0;
   logic [NS-1:0] sel_ab = '0, sel_ba = '0;
   logic [NS-1:0] oe_ab = '0, oe_ba_n = '1;
   logic [DW-1:0] a_out, b_out;
   logic [NS-1:0] a_oe, b_oe;

   int   n_run = 0;
   int   n_fail = 0;
   exp_t sb_q[$];
   event mon_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_xcvr_reg #(.DATA_W(DW), .NUM_SLICES(NS)) dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .a_ext_drv(a_ext_drv),
      .b_in(b_in), .b_ext_drv(b_ext_drv), .cap_ab(cap_ab), .cap_ba(cap_ba),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic expect_now(string req, logic [DW-1:0] ea, logic [DW-1:0] eb,
                             logic [NS-1:0] eoa, logic [NS-1:0] eob);
      exp_t e;
      #1;
      e.req = req; e.ea = ea; e.eb = eb; e.eoa = eoa; e.eob = eob;
      sb_q.push_back(e);
      ->mon_ev;
   endtask

   initial begin : monitor
      forever begin
         @(mon_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (a_out !== e.ea || b_out !== e.eb || a_oe !== e.eoa || b_oe !== e.eob) begin
               n_fail++;
               $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected a_out=%h b_out=%h a_oe=%b b_oe=%b",
                        e.req, a_out, b_out, a_oe, b_oe, e.ea, e.eb, e.eoa, e.eob);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      nxt(); rst = 1'b0;
      expect_now("R2 isolated after reset", 16'h0000, 16'h0000, 2'b00, 2'b00);

      // R1: stored data reads zero on both enabled outputs
      nxt(); oe_ab = 2'b11; sel_ab = 2'b11; oe_ba_n = 2'b00; sel_ba = 2'b11;
      expect_now("R1 stored zero", 16'h0000, 16'h0000, 2'b11, 2'b11);
      // R1: undriven A forwards cleared keeper
      nxt(); oe_ba_n = 2'b11; sel_ab = 2'b00;
      expect_now("R1 keeper zero", 16'h0000, 16'h0000, 2'b00, 2'b11);

      // R3 live A to B
      nxt(); a_ext_drv = 2'b11; a_in = 16'hA55A;
      expect_now("R3 live A to B", 16'h0000, 16'hA55A, 2'b00, 2'b11);

      // R4 live B to A
      nxt(); a_ext_drv = 2'b00; b_ext_drv = 2'b11; b_in = 16'h3CC3;
      oe_ab = 2'b00; oe_ba_n = 2'b00; sel_ba = 2'b00;
      expect_now("R4 live B to A", 16'h3CC3, 16'h0000, 2'b11, 2'b00);

      // R6 capture while isolated, R5 edge behaviour
      nxt(); oe_ba_n = 2'b11; b_ext_drv = 2'b00; a_ext_drv = 2'b11; a_in = 16'h1234; cap_ab = 2'b11;
      expect_now("R6 isolated during capture", 16'h0000, 16'h0000, 2'b00, 2'b00);
      nxt(); a_in = 16'hFFFF; oe_ab = 2'b11; sel_ab = 2'b11;
      expect_now("R6 captured while isolated", 16'h0000, 16'h1234, 2'b00, 2'b11);
      nxt();
      expect_now("R5 held strobe no reload", 16'h0000, 16'h1234, 2'b00, 2'b11);
      nxt(); cap_ab = 2'b00;
      expect_now("R5 strobe low keeps value", 16'h0000, 16'h1234, 2'b00, 2'b11);
      nxt(); cap_ab = 2'b11;
      expect_now("R5 not visible before edge", 16'h0000, 16'h1234, 2'b00, 2'b11);
      nxt(); cap_ab = 2'b00;
      expect_now("R5 second capture", 16'h0000, 16'hFFFF, 2'b00, 2'b11);

      // R7 B-to-A register
      nxt(); oe_ab = 2'b00; b_ext_drv = 2'b11; b_in = 16'h0F0F; cap_ba = 2'b11;
      expect_now("R7 isolated", 16'h0000, 16'h0000, 2'b00, 2'b00);
      nxt(); cap_ba = 2'b00; b_in = 16'h7777; oe_ba_n = 2'b00; sel_ba = 2'b11;
      expect_now("R7 stored B to A", 16'h0F0F, 16'h0000, 2'b11, 2'b00);

      // R8 capture from a bus the block drives
      nxt(); sel_ba = 2'b00; b_in = 16'h5AA5; a_ext_drv = 2'b00; cap_ab = 2'b11;
      expect_now("R8 A driven live", 16'h5AA5, 16'h0000, 2'b11, 2'b00);
      nxt(); cap_ab = 2'b00; oe_ba_n = 2'b11; b_ext_drv = 2'b00; oe_ab = 2'b11; sel_ab = 2'b11;
      expect_now("R8 captured driven value", 16'h0000, 16'h5AA5, 2'b00, 2'b11);

      // R12 select toggle with equal live and stored data
      nxt(); sel_ab = 2'b00;
      expect_now("R12 select toggle stable", 16'h0000, 16'h5AA5, 2'b00, 2'b11);

      // R9 keeper
      nxt(); oe_ab = 2'b00; a_ext_drv = 2'b11; a_in = 16'hBEEF;
      expect_now("R9 loading keeper", 16'h0000, 16'h0000, 2'b00, 2'b00);
      nxt(); a_ext_drv = 2'b00; a_in = 16'h0000; oe_ab = 2'b11;
      expect_now("R9 keeper forwarded", 16'h0000, 16'hBEEF, 2'b00, 2'b11);

      // R10 mutual reinforcement
      nxt(); a_ext_drv = 2'b11; a_in = 16'hC3C3;
      expect_now("R10 preload", 16'h0000, 16'hC3C3, 2'b00, 2'b11);
      nxt(); a_ext_drv = 2'b00; a_in = 16'h0000; oe_ba_n = 2'b00; sel_ba = 2'b00;
      expect_now("R10 loop entered", 16'hC3C3, 16'hC3C3, 2'b11, 2'b11);
      nxt(); b_in = 16'h1111;
      repeat (3) nxt();
      expect_now("R10 loop persists", 16'hC3C3, 16'hC3C3, 2'b11, 2'b11);

      // R11 slice independence
      nxt(); oe_ba_n = 2'b11; sel_ba = 2'b11; a_ext_drv = 2'b11; a_in = 16'h9876;
      sel_ab = 2'b10; cap_ab = 2'b10;
      expect_now("R11 mixed select", 16'h0000, 16'h5A76, 2'b00, 2'b11);
      nxt(); cap_ab = 2'b00; sel_ab = 2'b11;
      expect_now("R11 single slice capture", 16'h0000, 16'h98A5, 2'b00, 2'b11);

      // R1 reset mid-run
      nxt(); rst = 1'b1;
      nxt(); rst = 1'b0; a_ext_drv = 2'b00; sel_ab = 2'b10;
      expect_now("R1 cleared by reset", 16'h0000, 16'h0000, 2'b00, 2'b11);

      nxt();
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule